// File: doc/BRIEF.md
# UART FIFO Trigger and Reset Control

This block holds the transmit and receive byte queues of a UART, together with their occupancy counters. It decides when each direction should ask the host for service. Each queue has 64 entries. The serial side pushes received bytes and pops bytes to transmit. The host side does the opposite, and it sees a registered output byte on every pop.

A single control write configures the block. It carries an enable bit, two self-clearing queue-flush bits, two 2-bit threshold selectors and one bit with no function. A separate enhanced-mode input, sampled with the write, decides whether the transmit selector may change. A flush empties only the pointers and counter of its queue. It runs for a fixed number of cycles. While it runs, that queue refuses traffic and reports busy.

The receive request rises once the stored byte count is above the chosen receive threshold. The transmit request rises once the number of free slots is above the chosen transmit threshold. Every threshold is below 64, so an empty transmit queue always requests service.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Each queue holds 64 bytes. A push while the count is 64 (with no pop in the same cycle) is dropped, leaves the count at 64, and sets that queue's sticky overflow output.
- R2: Bytes leave each queue in the order they entered. The popped byte appears on the pop-data output in the cycle after the pop is accepted.
- R3: A pop from an empty queue leaves the count at 0 and keeps the pop-data output at the last byte delivered.
- R4: A control write with bit 0 = 1 and bit 1 = 1 flushes the receive queue, and one with bit 0 = 1 and bit 2 = 1 flushes the transmit queue. Busy goes high after the write edge and stays high for exactly 3 cycles, then returns to 0 by itself. The count and the overflow flag read 0 from the second cycle after the write. The other queue is untouched.
- R5: Flush bits written while bit 0 = 0 have no effect: busy stays 0 and the count is unchanged.
- R6: While a queue's busy is high, pushes to it and pops from it are ignored.
- R7: A flush does not alter the pop-data output.
- R8: Bits 7:6 select the receive threshold (00→8, 01→16, 10→56, 11→60). The receive request is 1 exactly when the receive count exceeds it.
- R9: Bits 5:4 select the transmit threshold in free slots (00→8, 01→16, 10→32, 11→56). The transmit request is 1 exactly when 64 minus the transmit count exceeds it.
- R10: When the enhanced-mode input is 0 during a write, bits 5:4 are ignored and the transmit threshold keeps its previous value.
- R11: Bit 3 of the control write has no effect.
- R12: After reset, both counts, both overflow flags and both busy outputs are 0, both selectors are 00, the receive request is 0 and the transmit request is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_data | input | 8 | Control byte |
| enh_mode | input | 1 | Enhanced-mode enable, sampled with cfg_we |
| rx_push | input | 1 | Push a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a received byte |
| rx_pop_data | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 7 | Receive queue occupancy |
| rx_overflow | output | 1 | Sticky receive overflow |
| rx_busy | output | 1 | Receive flush in progress |
| rx_irq | output | 1 | Receive service request |
| tx_push | input | 1 | Host writes a byte to send |
| tx_push_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Transmitter takes a byte |
| tx_pop_data | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 7 | Transmit queue occupancy |
| tx_overflow | output | 1 | Sticky transmit overflow |
| tx_busy | output | 1 | Transmit flush in progress |
| tx_irq | output | 1 | Transmit service request |

## Verification
The bench sweeps every count from 1 to 64 under every selector value in both directions. This catches a threshold compare that uses >= instead of >, and a transmit compare that counts bytes instead of free slots: either would flip a request one step early or at the wrong end. It times the flush to the cycle, so a sequencer that ran 2 or 4 cycles, cleared only on its last cycle, or dropped the enable gate shows a wrong busy or count. A write with enhanced mode off after the selector was set to 56 must leave the 56 boundary in place. A design that latched bits 5:4 anyway would move the boundary to 8.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEL_0 = 2'b00,
        SEL_1 = 2'b01,
        SEL_2 = 2'b10,
        SEL_3 = 2'b11
    } trig_sel_e;

    // receive threshold in stored bytes
    function automatic logic [7:0] rx_level(input trig_sel_e sel);
        case (sel)
            SEL_0:   rx_level = 8'd8;
            SEL_1:   rx_level = 8'd16;
            SEL_2:   rx_level = 8'd56;
            default: rx_level = 8'd60;
        endcase
    endfunction

    // transmit threshold in free slots
    function automatic logic [7:0] tx_level(input trig_sel_e sel);
        case (sel)
            SEL_0:   tx_level = 8'd8;
            SEL_1:   tx_level = 8'd16;
            SEL_2:   tx_level = 8'd32;
            default: tx_level = 8'd56;
        endcase
    endfunction

endpackage

// File: rtl/flush_seq.sv
module flush_seq #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] left;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start) begin
            s_d.busy = 1'b1;
            s_d.left = CW'(CYCLES - 1);
        end else if (s_q.busy) begin
            if (s_q.left == '0) s_d.busy = 1'b0;
            else                s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    // run-length checker: busy never lasts longer than CYCLES
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_q <= '0;
        else if (start)      run_q <= '0;
        else if (s_q.busy)   run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    assert_busy_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(run_q) < CYCLES));

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST   = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic [WIDTH-1:0] dout;
    } fifo_t;

    fifo_t s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        push_ok = push && !clr && (s_q.cnt != FULL);
        pop_ok  = pop  && !clr && (s_q.cnt != '0);
        s_d = s_q;
        if (clr) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
            s_d.ovf = 1'b0;
        end else begin
            if (push && !push_ok) s_d.ovf = 1'b1;
            if (push_ok) s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
            if (pop_ok) begin
                s_d.rd   = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
                s_d.dout = mem[s_q.rd];
            end
            if (push_ok && !pop_ok)      s_d.cnt = s_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wr] <= push_data;
    end

    assign pop_data = s_q.dout;
    assign count    = s_q.cnt;
    assign overflow = s_q.ovf;

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
    assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && count == FULL) |=> (count == FULL && overflow));
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr && count == '0) |=> (count == '0 && $stable(pop_data)));
    assert_flush_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !overflow));
    assert_flush_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> $stable(pop_data));

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int FLUSH_CYC  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [7:0]                  cfg_data,
    input  logic                        enh_mode,
    input  logic                        rx_push,
    input  logic [BYTE_W-1:0]           rx_push_data,
    input  logic                        rx_pop,
    output logic [BYTE_W-1:0]           rx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0]  rx_count,
    output logic                        rx_overflow,
    output logic                        rx_busy,
    output logic                        rx_irq,
    input  logic                        tx_push,
    input  logic [BYTE_W-1:0]           tx_push_data,
    input  logic                        tx_pop,
    output logic [BYTE_W-1:0]           tx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0]  tx_count,
    output logic                        tx_overflow,
    output logic                        tx_busy,
    output logic                        tx_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    // control byte fields
    localparam int B_EN = 0, B_RXF = 1, B_TXF = 2;

    typedef struct packed {
        logic      fifo_en;
        trig_sel_e rx_sel;
        trig_sel_e tx_sel;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic rx_start, tx_start;
    logic [CNT_W-1:0] rx_lvl, tx_lvl, tx_space;

    always_comb begin
        c_d = c_q;
        rx_start = 1'b0;
        tx_start = 1'b0;
        if (cfg_we) begin
            c_d.fifo_en = cfg_data[B_EN];
            c_d.rx_sel  = trig_sel_e'(cfg_data[7:6]);
            if (enh_mode) c_d.tx_sel = trig_sel_e'(cfg_data[5:4]);
            rx_start = cfg_data[B_EN] && cfg_data[B_RXF];
            tx_start = cfg_data[B_EN] && cfg_data[B_TXF];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{fifo_en: 1'b0, rx_sel: SEL_0, tx_sel: SEL_0};
        else        c_q <= c_d;
    end

    flush_seq #(.CYCLES(FLUSH_CYC)) u_rx_seq (
        .clk(clk), .rst_n(rst_n), .start(rx_start), .busy(rx_busy));
    flush_seq #(.CYCLES(FLUSH_CYC)) u_tx_seq (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .busy(tx_busy));

    byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_busy),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rx_pop), .pop_data(rx_pop_data),
        .count(rx_count), .overflow(rx_overflow));

    byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_busy),
        .push(tx_push), .push_data(tx_push_data),
        .pop(tx_pop), .pop_data(tx_pop_data),
        .count(tx_count), .overflow(tx_overflow));

    always_comb begin
        rx_lvl   = CNT_W'(rx_level(c_q.rx_sel));
        tx_lvl   = CNT_W'(tx_level(c_q.tx_sel));
        tx_space = FULL - tx_count;
        rx_irq   = rx_count > rx_lvl;
        tx_irq   = tx_space > tx_lvl;
    end

    assert_tx_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !enh_mode) |=> $stable(c_q.tx_sel));
    assert_rx_irq_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_count > CNT_W'(8)));
    assert_tx_irq_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> tx_irq);
    assert_no_flush_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_data[B_EN] && !rx_busy) |=> !rx_busy);

endmodule

// File: tb/uart_fifo_ctrl_test.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_data = '0;
    logic enh_mode = 1'b0;
    logic rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_push_data = '0, tx_push_data = '0;
    logic [7:0] rx_pop_data, tx_pop_data;
    logic [6:0] rx_count, tx_count;
    logic rx_overflow, tx_overflow, rx_busy, tx_busy, rx_irq, tx_irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_fifo_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .enh_mode(enh_mode),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_count(rx_count),
        .rx_overflow(rx_overflow), .rx_busy(rx_busy), .rx_irq(rx_irq),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_count(tx_count),
        .tx_overflow(tx_overflow), .tx_busy(tx_busy), .tx_irq(tx_irq));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rx_lvl(input int s);
        case (s) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
    endfunction
    function automatic int tx_lvl(input int s);
        case (s) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
    endfunction

    task automatic cycle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] d, input logic enh);
        cfg_we = 1'b1; cfg_data = d; enh_mode = enh;
        cycle();
        cfg_we = 1'b0; enh_mode = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d);
        rx_push = 1'b1; rx_push_data = d; cycle(); rx_push = 1'b0;
    endtask
    task automatic pop_rx();
        rx_pop = 1'b1; cycle(); rx_pop = 1'b0;
    endtask
    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_push_data = d; cycle(); tx_push = 1'b0;
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 rx_count", int'(rx_count), 0);
        check("R12 tx_count", int'(tx_count), 0);
        check("R12 rx_irq", int'(rx_irq), 0);
        check("R12 tx_irq", int'(tx_irq), 1);
        check("R12 busy", int'(rx_busy) + int'(tx_busy), 0);
        check("R12 overflow", int'(rx_overflow) + int'(tx_overflow), 0);

        // R2 order
        for (int i = 0; i < 5; i++) push_rx(8'hA0 + 8'(i));
        check("R2 count", int'(rx_count), 5);
        for (int i = 0; i < 5; i++) begin
            pop_rx();
            check("R2 order", int'(rx_pop_data), 32'hA0 + i);
        end
        // R3 empty pop
        pop_rx();
        check("R3 count", int'(rx_count), 0);
        check("R3 data", int'(rx_pop_data), 32'hA4);

        // R8 receive sweep over all selectors, R1 at the end
        tx_push_data = 8'h00;
        push_tx(8'h55); push_tx(8'h66);
        for (int s = 0; s < 4; s++) begin
            write_cfg({2'(s), 2'b00, 4'b0011}, 1'b0);
            repeat (3) cycle();
            check("R4 rx flushed", int'(rx_count), 0);
            for (int n = 1; n <= 64; n++) begin
                push_rx(8'(n));
                check("R8 rx_irq", int'(rx_irq), (n > rx_lvl(s)) ? 1 : 0);
            end
        end
        check("R1 full", int'(rx_count), 64);
        check("R1 no overflow yet", int'(rx_overflow), 0);
        push_rx(8'hFF);
        check("R1 count held", int'(rx_count), 64);
        check("R1 overflow", int'(rx_overflow), 1);
        pop_rx();
        check("R1 first byte kept", int'(rx_pop_data), 1);
        push_rx(8'h77);

        // R5 flush ignored when enable bit is 0
        write_cfg(8'b0000_0110, 1'b0);
        check("R5 busy", int'(rx_busy) + int'(tx_busy), 0);
        repeat (3) cycle();
        check("R5 rx_count", int'(rx_count), 64);
        check("R5 tx_count", int'(tx_count), 2);

        // R11 reserved bit
        write_cfg(8'b0000_1001, 1'b0);
        repeat (3) cycle();
        check("R11 busy", int'(rx_busy), 0);
        check("R11 rx_count", int'(rx_count), 64);
        check("R11 rx_irq", int'(rx_irq), 1);

        // R4 / R6 / R7 receive flush timing
        write_cfg(8'b0000_0011, 1'b0);
        check("R4 busy cycle1", int'(rx_busy), 1);
        check("R4 count before clear", int'(rx_count), 64);
        rx_push = 1'b1; rx_push_data = 8'h12; rx_pop = 1'b1;
        cycle();
        check("R4 busy cycle2", int'(rx_busy), 1);
        check("R4 count cleared", int'(rx_count), 0);
        check("R4 overflow cleared", int'(rx_overflow), 0);
        cycle();
        check("R4 busy cycle3", int'(rx_busy), 1);
        rx_push = 1'b0; rx_pop = 1'b0;
        cycle();
        check("R4 busy released", int'(rx_busy), 0);
        check("R6 blocked", int'(rx_count), 0);
        check("R7 pop data kept", int'(rx_pop_data), 1);
        check("R4 tx untouched", int'(tx_count), 2);
        check("R4 tx busy", int'(tx_busy), 0);

        // R9 transmit sweep with enhanced mode on
        for (int s = 0; s < 4; s++) begin
            write_cfg({2'b00, 2'(s), 4'b0101}, 1'b1);
            check("R4 tx busy", int'(tx_busy), 1);
            repeat (3) cycle();
            check("R4 tx flushed", int'(tx_count), 0);
            check("R9 tx_irq empty", int'(tx_irq), 1);
            for (int n = 1; n <= 64; n++) begin
                push_tx(8'(n));
                check("R9 tx_irq", int'(tx_irq), ((64 - n) > tx_lvl(s)) ? 1 : 0);
            end
        end

        // R10 selector held with enhanced mode off (currently 56)
        write_cfg(8'b0000_0101, 1'b0);
        repeat (3) cycle();
        for (int n = 1; n <= 64; n++) begin
            push_tx(8'(n));
            check("R10 tx_irq", int'(tx_irq), ((64 - n) > 56) ? 1 : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule